// File: doc/BRIEF.md
# Watchdog Heartbeat Period Extender

This block sits beside a set of per-core staged watchdogs (each of which raises an interrupt after one hardware period, escalates to a non-maskable interrupt after a second period, and resets the chip after a third). A single hardware period is often far shorter than the heartbeat software wants. The block stretches the heartbeat across many periods. It does this by servicing each core's watchdog interrupt itself. Each core keeps a budget of periods. Every interrupt that arrives while budget remains is answered with a poke to that core's watchdog, and the budget drops by one. When the budget is used up, the block stops poking and masks that core's interrupt. The watchdog then escalates to NMI and reset on its own.

Software sets the total heartbeat length as a number of hardware periods. The block keeps back two of these periods for the escalation stages. A global ping pokes every core, refills every budget and unmasks the interrupts. Countdown mode is switched on and off by start and stop pulses. While the mode is off, every interrupt is answered with a poke and the budget does not move.

Top module: `wdog_period_extender`

## Requirements
- R1: After synchronous reset, every poke output is 0, every interrupt mask bit is 0, and countdown mode is off.
- R2: The reload budget is `periods_i - 2` when `periods_i` is greater than 2, and 0 otherwise. After a ping in countdown mode, a core answers exactly that many interrupts with a poke before it masks.
- R3: In countdown mode, a rising edge on an unmasked core's interrupt while that core's budget is nonzero raises that core's poke for one cycle, starting in the cycle after the edge is sampled, and decrements the budget by one.
- R4: In countdown mode, a rising edge on an unmasked core's interrupt while that core's budget is zero produces no poke and sets that core's mask bit. Later interrupts on a masked core produce no poke until the mask is cleared.
- R5: With countdown mode off, every rising edge on an unmasked core's interrupt produces a poke, and the budget is left unchanged.
- R6: A ping raises every poke output for one cycle, loads the reload budget into every core, and clears every mask bit only if the reload budget is nonzero or countdown mode is off.
- R7: A start pulse performs a ping that is judged with the mode value held before the pulse, then turns countdown mode on. A stop pulse turns countdown mode off first, so its ping always clears the masks. If start and stop arrive together, stop wins.
- R8: Interrupts are edge detected, so an interrupt held high for several cycles yields at most one poke.
- R9: A ping (or start or stop) in the same cycle as an interrupt edge takes priority: the budget is reloaded and not decremented.
- R10: Cores are independent. An interrupt on one core changes no other core's poke, budget or mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_irq_i | input | NUM_CORES | Per-core watchdog interrupt, one bit per core |
| periods_i | input | CNT_W | Heartbeat length in hardware periods |
| ping_i | input | 1 | Global keepalive pulse |
| start_i | input | 1 | Enter countdown mode pulse |
| stop_i | input | 1 | Leave countdown mode pulse |
| poke_o | output | NUM_CORES | Registered one-cycle poke per core |
| irq_mask_o | output | NUM_CORES | Per-core interrupt mask state |
| cd_mode_o | output | 1 | Countdown mode flag |

## Verification
The per-core service path is exercised with single-cycle interrupt pulses, counted against budgets of 3, 2, 1 and 0 periods. The number of pokes before the mask closes tells a correct reload and decrement apart from an off-by-one. An interrupt held high for several cycles shows whether detection is by edge or by level. An interrupt that coincides with a ping shows which of the two wins. Pings and stop pulses with a zero budget separate the rule that unmasks the cores from the rule that pokes them. Pulses with the mode off show that the budget stays frozen while the mode is off.

// File: rtl/wpx_pkg.sv
package wpx_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_RELOAD = 2'd1,
    ACT_SERVE  = 2'd2,
    ACT_EXPIRE = 2'd3
  } wpx_act_e;

  localparam int unsigned ESCALATION_PERIODS = 2;
endpackage

// File: rtl/wpx_edge_det.sv
module wpx_edge_det #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] lvl_i,
  output logic [NUM_CORES-1:0] rise_o
);
  logic [NUM_CORES-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl_i;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_rise
      assign rise_o[g] = lvl_i[g] & ~lvl_d[g];

      // R8
      single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o[g] |=> !rise_o[g]);
    end
  endgenerate
endmodule

// File: rtl/wpx_mode_ctl.sv
module wpx_mode_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ping_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] periods_i,
  output logic             mode_o,
  output logic             ping_all_o,
  output logic             ping_mode_o,
  output logic [CNT_W-1:0] reload_o
);
  import wpx_pkg::*;

  localparam logic [CNT_W-1:0] ESC = CNT_W'(ESCALATION_PERIODS);

  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 1'b0;
    else if (stop_i)  mode_q <= 1'b0;
    else if (start_i) mode_q <= 1'b1;
  end

  always_comb begin
    reload_o    = (periods_i > ESC) ? (periods_i - ESC) : '0;
    ping_all_o  = ping_i | start_i | stop_i;
    ping_mode_o = stop_i ? 1'b0 : mode_q;
    mode_o      = mode_q;
  end

  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !mode_q);
  // R7
  start_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> mode_q);
endmodule

// File: rtl/wpx_core_ctr.sv
module wpx_core_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             mode_i,
  input  logic             ping_i,
  input  logic             ping_mode_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             poke_o,
  output logic             mask_o
);
  import wpx_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             mask_q;
  logic             poke_q;
  wpx_act_e         act;

  always_comb begin
    if (ping_i)                 act = ACT_RELOAD;
    else if (rise_i && !mask_q) act = (!mode_i || cnt_q != '0) ? ACT_SERVE : ACT_EXPIRE;
    else                        act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mask_q <= 1'b0;
      poke_q <= 1'b0;
    end else begin
      poke_q <= 1'b0;
      unique case (act)
        ACT_RELOAD: begin
          poke_q <= 1'b1;
          cnt_q  <= reload_i;
          if (reload_i != '0 || !ping_mode_i) mask_q <= 1'b0;
        end
        ACT_SERVE: begin
          poke_q <= 1'b1;
          if (mode_i) cnt_q <= cnt_q - 1'b1;
        end
        ACT_EXPIRE: mask_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign poke_o = poke_q;
  assign mask_o = mask_q;

  // R3
  serve_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_i && !mask_q && mode_i && !ping_i && cnt_q != '0)
      |=> (poke_q && cnt_q == $past(cnt_q) - 1'b1));
  // R4
  expire_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_i && !mask_q && mode_i && !ping_i && cnt_q == '0) |=> (!poke_q && mask_q));
  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !ping_i) |=> !poke_q);
  // R5
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_i && !mask_q && !mode_i && !ping_i) |=> (poke_q && $stable(cnt_q)));
  // R6
  ping_reload_chk: assert property (@(posedge clk) disable iff (rst)
    ping_i |=> (poke_q && cnt_q == $past(reload_i)));
endmodule

// File: rtl/wdog_period_extender.sv
module wdog_period_extender #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] wdt_irq_i,
  input  logic [CNT_W-1:0]     periods_i,
  input  logic                 ping_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  output logic [NUM_CORES-1:0] poke_o,
  output logic [NUM_CORES-1:0] irq_mask_o,
  output logic                 cd_mode_o
);
  logic [NUM_CORES-1:0] rise;
  logic                 ping_all;
  logic                 ping_mode;
  logic                 mode;
  logic [CNT_W-1:0]     reload;

  wpx_edge_det #(.NUM_CORES(NUM_CORES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (wdt_irq_i),
    .rise_o(rise)
  );

  wpx_mode_ctl #(.CNT_W(CNT_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .ping_i     (ping_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .periods_i  (periods_i),
    .mode_o     (mode),
    .ping_all_o (ping_all),
    .ping_mode_o(ping_mode),
    .reload_o   (reload)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_core
      wpx_core_ctr #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise[g]),
        .mode_i     (mode),
        .ping_i     (ping_all),
        .ping_mode_i(ping_mode),
        .reload_i   (reload),
        .poke_o     (poke_o[g]),
        .mask_o     (irq_mask_o[g])
      );
    end
  endgenerate

  assign cd_mode_o = mode;

  // R6
  ping_all_poke_chk: assert property (@(posedge clk) disable iff (rst)
    ping_all |=> (poke_o == {NUM_CORES{1'b1}}));
  // R10
  lone_poke_chk: assert property (@(posedge clk) disable iff (rst)
    (!ping_all && $onehot0(rise)) |=> $onehot0(poke_o));
endmodule

// File: tb/test_wdog_period_extender.sv
`timescale 1ns/1ps
module test_wdog_period_extender;
  localparam int NC = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] irq = '0;
  logic [CW-1:0] periods = '0;
  logic          ping = 1'b0, start = 1'b0, stop = 1'b0;
  logic [NC-1:0] poke, mask;
  logic          mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_period_extender #(.NUM_CORES(NC), .CNT_W(CW)) i_wdog_period_extender (
    .clk(clk), .rst(rst), .wdt_irq_i(irq), .periods_i(periods),
    .ping_i(ping), .start_i(start), .stop_i(stop),
    .poke_o(poke), .irq_mask_o(mask), .cd_mode_o(mode)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // one-cycle interrupt pulse on core c; poke visible after the next negedge
  task automatic irq_pulse(int c, bit exp_poke, string tag);
    @(negedge clk); irq[c] = 1'b1;
    @(negedge clk); irq[c] = 1'b0;
    check({tag, " poke"}, {28'd0, poke}, exp_poke ? (32'd1 << c) : 32'd0);
  endtask

  task automatic pulse_ctl(bit p, bit s, bit t);
    @(negedge clk); ping = p; start = s; stop = t;
    @(negedge clk); ping = 0; start = 0; stop = 0;
  endtask

  task automatic t_reset;
    check("R1 poke", {28'd0, poke}, 0);
    check("R1 mask", {28'd0, mask}, 0);
    check("R1 mode", {31'd0, mode}, 0);
  endtask

  task automatic t_budget_three;
    periods = 16'd5;
    pulse_ctl(0, 1, 0);
    check("R7 start pokes all", {28'd0, poke}, 32'hF);
    check("R7 mode on", {31'd0, mode}, 1);
    for (int i = 0; i < 3; i++) irq_pulse(0, 1, "R3 serve");
    irq_pulse(0, 0, "R4 expire");
    check("R4 mask set", {28'd0, mask}, 32'h1);
    irq_pulse(0, 0, "R4 masked ignored");
    irq_pulse(1, 1, "R10 other core served");
    check("R10 masks", {28'd0, mask}, 32'h1);
  endtask

  task automatic t_ping_refill;
    pulse_ctl(1, 0, 0);
    check("R6 ping pokes all", {28'd0, poke}, 32'hF);
    check("R6 ping unmask", {28'd0, mask}, 0);
    for (int i = 0; i < 3; i++) irq_pulse(0, 1, "R2 reload 3");
    irq_pulse(0, 0, "R2 reload 3 end");
  endtask

  task automatic t_zero_budget;
    periods = 16'd2;
    pulse_ctl(1, 0, 0);
    irq_pulse(1, 0, "R2 reload 0");
    check("R4 mask1", {28'd0, mask[1]}, 1);
    pulse_ctl(1, 0, 0);
    check("R6 zero ping pokes", {28'd0, poke}, 32'hF);
    check("R6 zero ping keeps mask", {31'd0, mask[1]}, 1);
    pulse_ctl(0, 0, 1);
    check("R7 stop unmasks", {28'd0, mask}, 0);
    check("R7 mode off", {31'd0, mode}, 0);
    for (int i = 0; i < 4; i++) irq_pulse(1, 1, "R5 free run");
  endtask

  task automatic t_level;
    @(negedge clk); irq[2] = 1'b1;
    @(negedge clk);
    check("R8 first poke", {28'd0, poke}, 32'h4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 held no poke", {28'd0, poke}, 0);
    end
    irq[2] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reload_one;
    periods = 16'd3;
    pulse_ctl(0, 1, 0);
    irq_pulse(2, 1, "R2 reload 1 serve");
    irq_pulse(2, 0, "R2 reload 1 end");
    periods = 16'd1;
    pulse_ctl(1, 0, 0);
    check("R6 reload0 mode on keeps mask", {31'd0, mask[2]}, 1);
    irq_pulse(3, 0, "R2 periods 1");
  endtask

  task automatic t_collide;
    periods = 16'd4;
    pulse_ctl(0, 1, 0);
    check("R7 start unmask", {28'd0, mask}, 0);
    irq_pulse(3, 1, "R9 pre");
    @(negedge clk); irq[3] = 1'b1; ping = 1'b1;
    @(negedge clk); irq[3] = 1'b0; ping = 1'b0;
    check("R9 ping wins poke", {28'd0, poke}, 32'hF);
    irq_pulse(3, 1, "R9 after a");
    irq_pulse(3, 1, "R9 after b");
    irq_pulse(3, 0, "R9 after end");
  endtask

  task automatic t_both;
    pulse_ctl(0, 1, 1);
    check("R7 stop wins", {31'd0, mode}, 0);
    check("R7 both unmask", {28'd0, mask}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_budget_three();
    t_ping_refill();
    t_zero_budget();
    t_level();
    t_reload_one();
    t_collide();
    t_both();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule